// File: doc/BRIEF.md
# Presettable Cascadable Decade/Binary Counter

This block is a 4-bit synchronous counter. Its modulus is fixed at build time: it counts either 0 to 9 in decimal digits or 0 to 15 in plain binary. A second build-time choice sets how the clear input acts. It can clear the count at once, without waiting for the clock. It can also clear only on a rising clock edge, and then it overrides every other control.

There is one load input and one data input. Driving the load low copies the data into the counter. Counting needs two enables to be high together. The first enable is driven in common to every stage of a chain. The second enable is chained from one stage to the next. The terminal-count output is combinational. It is high only when the chained enable is high and the count is at its highest value. Wiring each stage's terminal count to the next stage's chained enable gives a multi-digit counter with no ripple and no extra gates.

In decimal mode the counter may be loaded with a code from 10 to 15. From any such code it returns to the 0 to 9 sequence within two counting edges.

Top module: `cascade_counter`

## Requirements
- R1: With `ASYNC_CLR=1`, a low `clr_n` forces `q` to 0 at once, without a clock edge and whatever the other inputs are. `q` stays 0 while `clr_n` is low.
- R2: With `ASYNC_CLR=0`, a low `clr_n` at a rising edge sets `q` to 0 on that edge. This clear overrides `load_n`, `en_par` and `en_trk`.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` (bit 0 is the LSB), whatever the enables are.
- R4: When `clr_n` and `load_n` are high and both `en_par` and `en_trk` are high, `q` increments by one on the rising edge.
- R5: When `clr_n` and `load_n` are high and either enable is low, `q` keeps its value.
- R6: `tc` is 1 exactly when `en_trk` is 1 and `q` is at its highest value. That value is 9 (4'b1001) when `DECADE=1` and 15 (4'b1111) when `DECADE=0`.
- R7: Counting from the highest value (9 or 15) gives 0.
- R8: With `DECADE=1`, any of the 16 codes can be loaded, and codes 10 to 15 never raise `tc`. Counting moves 10→11→6, 12→13→4 and 14→15→2.
- R9: `en_par` has no effect on `tc`. Stages chained by terminal count into `en_trk`, with `en_par` shared, count as one multi-digit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Active-low clear, asynchronous or edge-timed by parameter |
| load_n | input | 1 | Active-low parallel load |
| din | input | 4 | Parallel load data |
| en_par | input | 1 | Count enable shared by all stages |
| en_trk | input | 1 | Count enable chained between stages; also gates `tc` |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal count |

## Verification
On every cycle, the assertions check each edge's result against the controls sampled at that edge. They cover the clear, load, count, hold and wrap results, and the steps out of the decimal codes 10 to 15. They also check that `tc` is high only under its two conditions, and that an unused code never raises it.

Some results need bench scenarios instead. These are:
- a clear that falls between edges;
- the full priority order when several controls are active together;
- a chain of decimal stages keeping in step over a carry.

// File: rtl/cnt_pkg.sv
// Package: shared width, operation encoding and modulus helpers for the
// cascadable counter. Assumes a 4-bit counting stage.
package cnt_pkg;
    localparam int CNT_W = 4;

    // Operation chosen for the next clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Highest code of the counting sequence for the selected modulus.
    function automatic logic [CNT_W-1:0] top_code(input bit decade);
        return decade ? CNT_W'(9) : {CNT_W{1'b1}};
    endfunction
endpackage

// File: rtl/cnt_mode_sel.sv
// Module: cnt_mode_sel
// Picks the operation for the next edge: clear, then load, then count,
// then hold. When the clear is asynchronous it is handled at the register,
// so here it is ignored. Assumes all controls are active at the same edge.
module cnt_mode_sel
    import cnt_pkg::*;
#(
    parameter bit EDGE_CLR = 1'b1
) (
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);
    logic clr_hit;

    // Clear is an edge-timed operation only in the edge-clear variant.
    generate
        if (EDGE_CLR) begin : g_edge_clr
            assign clr_hit = ~clr_n;
        end else begin : g_no_edge_clr
            assign clr_hit = 1'b0;
        end
    endgenerate

    // Priority decode of the mode controls.
    always_comb begin
        if (clr_hit)                op = OP_CLEAR;
        else if (!load_n)           op = OP_LOAD;
        else if (en_par && en_trk)  op = OP_COUNT;
        else                        op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_next_state.sv
// Module: cnt_next_state
// Computes the register input from the current count, the chosen operation
// and the load data. In decimal mode the unused codes 10..15 are steered
// back into 0..9: even codes step up by one, odd codes jump to 17 - code.
module cnt_next_state
    import cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] TOP = top_code(DECADE);

    logic [CNT_W-1:0] succ;

    // Successor of the current count for the chosen modulus.
    generate
        if (DECADE) begin : g_dec
            logic [CNT_W:0] jump;
            assign jump = (CNT_W+1)'(17) - {1'b0, cur};
            always_comb begin
                if (cur < TOP)       succ = cur + 1'b1;
                else if (cur == TOP) succ = '0;
                else if (!cur[0])    succ = cur + 1'b1;
                else                 succ = jump[CNT_W-1:0];
            end
        end else begin : g_bin
            always_comb succ = cur + 1'b1;
        end
    endgenerate

    // Route the selected source to the register input.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = succ;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_tc_decode.sv
// Module: cnt_tc_decode
// Full decode of the highest code, gated only by the chained enable, so a
// chain of stages forms its carry without any clocked delay.
module cnt_tc_decode
    import cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    localparam logic [CNT_W-1:0] TOP = top_code(DECADE);

    // Terminal count: chained enable AND count at highest code.
    always_comb tc = en_trk && (cur == TOP);
endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter
// Top of the presettable 4-bit counter. DECADE picks mod 10 or mod 16.
// ASYNC_CLR picks an immediate clear or an edge-timed clear. Assumes the
// inputs are synchronous to clk, except clr_n in the immediate variant.
module cascade_counter
    import cnt_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [CNT_W-1:0] q,
    output logic             tc
);
    localparam logic [CNT_W-1:0] TOP = top_code(DECADE);

    cnt_op_e          op;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cnt_q;

    cnt_mode_sel #(.EDGE_CLR(!ASYNC_CLR)) u_mode (
        .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk), .op(op)
    );

    cnt_next_state #(.DECADE(DECADE)) u_next (
        .cur(cnt_q), .op(op), .din(din), .nxt(nxt)
    );

    cnt_tc_decode #(.DECADE(DECADE)) u_tc (
        .cur(cnt_q), .en_trk(en_trk), .tc(tc)
    );

    // Count register; the variant picks how the clear reaches it.
    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) cnt_q <= '0;
                else        cnt_q <= nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) cnt_q <= nxt;
        end
    endgenerate

    assign q = cnt_q;

    // ---------------- assertions ----------------
    logic past_ok = 1'b0;
    // Marks that one edge has passed, so $past has real history.
    always_ff @(posedge clk) past_ok <= 1'b1;

    generate
        if (ASYNC_CLR) begin : g_a_async
            a_r1_async_clear_holds_zero: assert property (@(posedge clk)
                past_ok && !clr_n |-> q == '0);
        end else begin : g_a_sync
            a_r2_edge_clear_wins: assert property (@(posedge clk)
                past_ok && !$past(clr_n) |-> q == '0);
        end
    endgenerate

    a_r3_load_takes_data: assert property (@(posedge clk) disable iff (!clr_n)
        past_ok && $past(clr_n) && !$past(load_n) |-> q == $past(din));

    a_r4_count_steps_up: assert property (@(posedge clk) disable iff (!clr_n)
        past_ok && $past(clr_n && load_n && en_par && en_trk) && ($past(q) < TOP)
        |-> q == $past(q) + 1'b1);

    a_r7_count_wraps: assert property (@(posedge clk) disable iff (!clr_n)
        past_ok && $past(clr_n && load_n && en_par && en_trk) && ($past(q) == TOP)
        |-> q == '0);

    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!clr_n)
        past_ok && $past(clr_n && load_n) && !$past(en_par && en_trk)
        |-> $stable(q));

    a_r6_tc_needs_trickle: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> en_trk);

    a_r6_tc_at_top: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> q == TOP);

    generate
        if (DECADE) begin : g_a_dec
            a_r8_unused_no_tc: assert property (@(posedge clk) disable iff (!clr_n)
                q > TOP |-> !tc);
            a_r8_odd_unused_returns: assert property (@(posedge clk) disable iff (!clr_n)
                past_ok && $past(clr_n && load_n && en_par && en_trk)
                && ($past(q) > TOP) && $past(q[0]) |-> q <= TOP);
            a_r8_even_unused_steps: assert property (@(posedge clk) disable iff (!clr_n)
                past_ok && $past(clr_n && load_n && en_par && en_trk)
                && ($past(q) > TOP) && !$past(q[0]) |-> q == $past(q) + 1'b1);
        end
    endgenerate
endmodule

// File: tb/cascade_counter_bench.sv
// Bench: a vector table walked on a decimal unit with edge-timed clear, then
// directed tests on a binary unit with immediate clear, then a two-digit
// decimal chain.
module cascade_counter_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       clr_n;
        logic       load_n;
        logic [3:0] din;
        logic       ep;
        logic       et;
        logic [3:0] exp_q;
        logic       exp_tc;
    } vec_t;

    localparam int NV = 25;
    // clr_n load_n din ep et | q tc after the edge
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // R2 clear
        '{1'b1, 1'b0, 4'd7,  1'b1, 1'b1, 4'd7,  1'b0}, // R3 load
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  1'b0}, // R4 count
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  1'b1}, // R6 tc at 9
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // R7 wrap
        '{1'b1, 1'b0, 4'd9,  1'b0, 1'b0, 4'd9,  1'b0}, // R3 load, enables low; R6 et low
        '{1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  1'b1}, // R5 hold ep low; R9 tc
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 4'd9,  1'b0}, // R5 hold et low; R6
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // R7 wrap
        '{1'b1, 1'b0, 4'd5,  1'b1, 1'b1, 4'd5,  1'b0}, // R3
        '{1'b0, 1'b0, 4'd3,  1'b1, 1'b1, 4'd0,  1'b0}, // R2 clear beats load
        '{1'b1, 1'b0, 4'd10, 1'b1, 1'b1, 4'd10, 1'b0}, // R8 load 10
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd11, 1'b0}, // R8
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd6,  1'b0}, // R8
        '{1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 1'b0}, // R8 load 12
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd13, 1'b0}, // R8
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd4,  1'b0}, // R8
        '{1'b1, 1'b0, 4'd14, 1'b1, 1'b1, 4'd14, 1'b0}, // R8 load 14
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 1'b0}, // R8 no tc at 15
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd2,  1'b0}, // R8
        '{1'b1, 1'b0, 4'd11, 1'b0, 1'b1, 4'd11, 1'b0}, // R8 odd code held
        '{1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd11, 1'b0}, // R5 hold on unused
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd6,  1'b0}, // R8
        '{1'b0, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0}, // R2 clear beats count
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd1,  1'b0}  // R4
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Unit A: decimal, edge-timed clear
    logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_ep = 1'b0, a_et = 1'b0;
    logic [3:0] a_din = '0, a_q;
    logic       a_tc;
    cascade_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_cascade_counter (
        .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .din(a_din),
        .en_par(a_ep), .en_trk(a_et), .q(a_q), .tc(a_tc));

    // Unit B: binary, immediate clear
    logic       b_clr_n = 1'b0, b_load_n = 1'b1, b_ep = 1'b0, b_et = 1'b0;
    logic [3:0] b_din = '0, b_q;
    logic       b_tc;
    cascade_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b1)) u_bin (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .din(b_din),
        .en_par(b_ep), .en_trk(b_et), .q(b_q), .tc(b_tc));

    // Chain: two decimal stages, low digit carries into high digit
    logic       c_clr_n = 1'b0, c_ep = 1'b0;
    logic [3:0] lo_q, hi_q;
    logic       lo_tc, hi_tc;
    cascade_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
        .en_par(c_ep), .en_trk(1'b1), .q(lo_q), .tc(lo_tc));
    cascade_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
        .en_par(c_ep), .en_trk(lo_tc), .q(hi_q), .tc(hi_tc));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        edge_settle();
        check("R2 reset state q", a_q, 0);
        check("R1 reset state q", b_q, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            a_clr_n = VEC[i].clr_n; a_load_n = VEC[i].load_n; a_din = VEC[i].din;
            a_ep = VEC[i].ep; a_et = VEC[i].et;
            edge_settle();
            check($sformatf("R2-R9 vector %0d q", i), a_q, VEC[i].exp_q);
            check($sformatf("R6 vector %0d tc", i), a_tc, VEC[i].exp_tc);
        end

        // binary unit: wrap at 15 and tc
        b_clr_n = 1'b1; b_load_n = 1'b0; b_din = 4'd14; b_ep = 1'b1; b_et = 1'b1;
        edge_settle();
        check("R3 binary load", b_q, 14);
        b_load_n = 1'b1;
        edge_settle();
        check("R4 binary count", b_q, 15);
        check("R6 binary tc at 15", b_tc, 1);
        b_ep = 1'b0;
        #1 check("R9 tc with en_par low", b_tc, 1);
        b_ep = 1'b1;
        edge_settle();
        check("R7 binary wrap", b_q, 0);
        check("R6 binary tc low", b_tc, 0);

        // immediate clear in mid-cycle
        b_load_n = 1'b0; b_din = 4'd5;
        edge_settle();
        b_load_n = 1'b1; b_ep = 1'b0;
        check("R3 binary load 5", b_q, 5);
        #2 b_clr_n = 1'b0;
        #1 check("R1 clear between edges", b_q, 0);
        b_load_n = 1'b0; b_din = 4'd9; b_ep = 1'b1;
        edge_settle();
        check("R1 clear held over edge beats load", b_q, 0);
        b_clr_n = 1'b1; b_load_n = 1'b1;
        edge_settle();
        check("R4 count after clear release", b_q, 1);

        // two-digit chain
        c_clr_n = 1'b0;
        edge_settle();
        c_clr_n = 1'b1; c_ep = 1'b1;
        for (int n = 1; n <= 25; n++) begin
            edge_settle();
            check($sformatf("R9 chain low digit at %0d", n), lo_q, n % 10);
            check($sformatf("R9 chain high digit at %0d", n), hi_q, (n / 10) % 10);
        end
        c_ep = 1'b0;
        edge_settle();
        check("R5 chain hold low", lo_q, 5);
        check("R5 chain hold high", hi_q, 2);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule